// File: doc/BRIEF.md
# SONET Receive Frame Aligner

This block sits behind clock and data recovery on a SONET/SDH receive path. It takes the recovered serial stream, one bit per bit clock, and looks for the framing word that sits at the junction of the A1 and A2 bytes in the transport overhead. When it finds that word, it fixes the byte boundary. From then on it delivers aligned bytes, each with a one-cycle byte strobe, and raises a frame pulse on the first byte after each framing word.

The alignment hunt is gated from outside. While the out-of-frame input is high, every bit position is compared against the framing word, and any match moves the boundary. While the input is low, the boundary and the in-frame byte counter run freely, and a framing word at some other offset does not disturb them. After reset the block hunts on its own until it locks the first time. One mode input selects between the STS-3 frame (2430 bytes) and the STS-12 frame (9720 bytes).

Top module: `sonet_frame_aligner`

## Requirements
- R1: Out of reset, `frame_pulse`, `byte_stb` and `byte_out` are all zero. The block hunts whatever the level of `oof`, and `frame_pulse` stays low until the first framing word has been found.
- R2: Outside a realignment, `byte_stb` is high for exactly one bit clock in every eight. `byte_out` changes only in a cycle where `byte_stb` is high.
- R3: The framing word is 48 bits, with the first-received bit as its MSB: the bytes 0xF6, 0xF6, 0xF6, 0x28, 0x28, 0x28. These are the last three A1 bytes (A1 = 0xF6) followed by the first three A2 bytes (A2 = 0x28), compared on the serial stream.
- R4: After a match, the first byte delivered is the byte whose first bit follows the last bit of the framing word. In STS-12 this is the fourth A2 byte; in STS-3 it is the byte after the last A2. Bytes are assembled MSB first.
- R5: `frame_pulse` rises only together with `byte_stb`. It is high for the one byte period of the first byte after the framing word and low for the next byte.
- R6: While no realignment occurs, `frame_pulse` repeats every 2430 byte strobes when `sts12_mode` is 0, and every 9720 byte strobes when it is 1.
- R7: With `oof` low after lock, a framing word at a different bit offset is ignored. The next frame pulse falls exactly one frame length of byte strobes after the previous one.
- R8: With `oof` high, a match at any bit offset realigns the boundary within one bit clock. The partially gathered byte is dropped, so no strobe is given in the next cycle.
- R9: `sts12_mode` selects the frame length (2430 or 9720 bytes), and with it the position of the delivered byte that follows the framing word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial receive data, sampled on each rising edge |
| oof | input | 1 | Out-of-frame; high enables realignment on every bit offset |
| sts12_mode | input | 1 | 0 selects STS-3 geometry, 1 selects STS-12 geometry |
| byte_out | output | 8 | Aligned byte, first-received bit in bit 7 |
| byte_stb | output | 1 | One-clock strobe when `byte_out` holds a new byte |
| frame_pulse | output | 1 | High during the byte period of the first byte after the framing word |

## Verification
The hardest case to create is a framing word that arrives at the wrong bit offset after lock. The stimulus slips the serial stream by a few stray bits while `oof` stays low and then sends whole frames. The bench then checks that the next frame pulse lands exactly one frame length after the old one, counting byte strobes. A second run raises `oof` and resends frames on the shifted stream, which must move the boundary.

// File: rtl/sfa_pkg.sv
// Package: shared constants and helpers for the SONET frame aligner.
// Assumes the first-received bit of each byte is its MSB.
package sfa_pkg;

    localparam int          BYTE_W     = 8;
    localparam int          PAT_SIDE   = 3;                     // A1 bytes, then A2 bytes, in the word
    localparam int          PAT_W      = 2 * PAT_SIDE * BYTE_W; // 48-bit framing word
    localparam logic [7:0]  A1_BYTE    = 8'hF6;
    localparam logic [7:0]  A2_BYTE    = 8'h28;

    // Build the framing word: PAT_SIDE A1 bytes, then PAT_SIDE A2 bytes.
    function automatic logic [PAT_W-1:0] framing_word();
        logic [PAT_W-1:0] w;
        w = '0;
        for (int i = 0; i < 2 * PAT_SIDE; i++) begin
            w = {w[PAT_W-BYTE_W-1:0], (i < PAT_SIDE) ? A1_BYTE : A2_BYTE};
        end
        return w;
    endfunction

endpackage

// File: rtl/sfa_shifter.sv
// Serial shift window and framing-word comparator.
// Shifts ser_in in on every bit clock with the newest bit at the LSB, and
// flags a match when the registered window holds the whole framing word.
// Assumes the serial stream arrives MSB first.
module sfa_shifter #(
    parameter int WIN_W  = sfa_pkg::PAT_W,
    parameter int BYTE_W = sfa_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    output logic              pat_match,
    output logic [BYTE_W-1:0] next_byte
);
    localparam logic [WIN_W-1:0] PATTERN = sfa_pkg::framing_word();

    logic [WIN_W-1:0] window;

    // Shift the incoming bit into the comparison window.
    always_ff @(posedge clk) begin
        if (!rst_n) window <= '0;
        else        window <= {window[WIN_W-2:0], ser_in};
    end

    // Compare the whole window against the framing word.
    always_comb pat_match = (window == PATTERN);

    // Byte that is complete once the current input bit has been taken.
    always_comb next_byte = {window[BYTE_W-2:0], ser_in};
endmodule

// File: rtl/sfa_bit_timer.sv
// Bit-in-byte counter that sets the byte boundary.
// On realign, the bit taken in that cycle is counted as the first bit of a
// new byte. byte_last marks the cycle that takes the final bit of a byte.
module sfa_bit_timer #(
    parameter int BYTE_W = sfa_pkg::BYTE_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic realign,
    output logic byte_last
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [CNT_W-1:0] bit_cnt;

    // Count bits already gathered into the current byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       bit_cnt <= '0;
        else if (realign) bit_cnt <= CNT_W'(1);
        else if (byte_last) bit_cnt <= '0;
        else              bit_cnt <= bit_cnt + CNT_W'(1);
    end

    // The eighth bit of a byte is taken in this cycle.
    always_comb byte_last = (bit_cnt == CNT_W'(BYTE_W - 1));
endmodule

// File: rtl/sfa_frame_counter.sv
// Byte position within the frame, with a length chosen by mode.
// Position 0 is the first byte after the framing word. Realign restarts
// the count; advance steps it once per delivered byte, wrapping at the
// frame length.
module sfa_frame_counter #(
    parameter int ROWS      = 9,
    parameter int STS1_COLS = 90,
    parameter int LOW_N     = 3,
    parameter int HIGH_N    = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sts12_mode,
    input  logic realign,
    input  logic advance,
    output logic at_start
);
    localparam int LEN_LOW  = ROWS * STS1_COLS * LOW_N;
    localparam int LEN_HIGH = ROWS * STS1_COLS * HIGH_N;
    localparam int POS_W    = $clog2(LEN_HIGH);

    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] last_pos;

    // Last byte index of the frame for the selected geometry.
    always_comb last_pos = sts12_mode ? POS_W'(LEN_HIGH - 1) : POS_W'(LEN_LOW - 1);

    // Track the byte position, restarting on realignment.
    always_ff @(posedge clk) begin
        if (!rst_n)        pos <= '0;
        else if (realign)  pos <= '0;
        else if (advance)  pos <= (pos >= last_pos) ? '0 : pos + POS_W'(1);
    end

    // The byte now completing is the first one of a frame.
    always_comb at_start = (pos == '0);
endmodule

// File: rtl/sonet_frame_aligner.sv
// SONET receive frame aligner, top level.
// Finds the A1/A2 framing word on the serial stream and fixes the byte
// boundary from it. Delivers MSB-first bytes with a one-clock strobe and
// flags the first byte of each frame. Realignment is allowed while oof is
// high, and during the hunt that follows reset until the first lock.
// Assumes ser_in is already retimed to clk.
module sonet_frame_aligner #(
    parameter int ROWS      = 9,
    parameter int STS1_COLS = 90
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_in,
    input  logic       oof,
    input  logic       sts12_mode,
    output logic [7:0] byte_out,
    output logic       byte_stb,
    output logic       frame_pulse
);
    logic       pat_match;
    logic [7:0] next_byte;
    logic       byte_last;
    logic       at_start;
    logic       hunt;
    logic       realign;
    logic       byte_done;

    sfa_shifter #(.WIN_W(sfa_pkg::PAT_W), .BYTE_W(8)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_in    (ser_in),
        .pat_match (pat_match),
        .next_byte (next_byte)
    );

    // Realignment is allowed when out-of-frame, or before the first lock.
    always_comb realign   = pat_match && (oof || hunt);
    always_comb byte_done = byte_last && !realign;

    sfa_bit_timer #(.BYTE_W(8)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .realign   (realign),
        .byte_last (byte_last)
    );

    sfa_frame_counter #(.ROWS(ROWS), .STS1_COLS(STS1_COLS)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .sts12_mode (sts12_mode),
        .realign    (realign),
        .advance    (byte_done),
        .at_start   (at_start)
    );

    // Hunt flag: set by reset, cleared by the first lock.
    always_ff @(posedge clk) begin
        if (!rst_n)       hunt <= 1'b1;
        else if (realign) hunt <= 1'b0;
    end

    // Output register: byte, strobe and frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_out    <= '0;
            byte_stb    <= 1'b0;
            frame_pulse <= 1'b0;
        end else begin
            byte_stb <= 1'b0;
            if (realign) begin
                frame_pulse <= 1'b0;
            end else if (byte_done) begin
                byte_out    <= next_byte;
                byte_stb    <= 1'b1;
                frame_pulse <= at_start && !hunt;
            end
        end
    end
endmodule

// File: rtl/sfa_checker.sv
// Checker for the SONET frame aligner: properties over its outputs and
// hunt state. Attached to the top with bind below.
module sfa_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       oof,
    input logic       pat_match,
    input logic       hunt,
    input logic [7:0] byte_out,
    input logic       byte_stb,
    input logic       frame_pulse
);
    assert_no_pulse_hunting_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hunt |-> !frame_pulse);

    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |=> !byte_stb);

    assert_byte_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_stb |-> $stable(byte_out));

    assert_pulse_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_pulse) |-> byte_stb);

    assert_realign_drops_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (oof && pat_match) |=> !byte_stb);
endmodule

bind sonet_frame_aligner sfa_checker u_sfa_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .oof         (oof),
    .pat_match   (pat_match),
    .hunt        (hunt),
    .byte_out    (byte_out),
    .byte_stb    (byte_stb),
    .frame_pulse (frame_pulse)
);

// File: tb/test_sonet_frame_aligner.sv
`timescale 1ns/1ps
module test_sonet_frame_aligner;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       oof = 1'b0;
    logic       sts12_mode = 1'b0;
    logic [7:0] byte_out;
    logic       byte_stb;
    logic       frame_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int last_pulse = -1;
    bit done     = 1'b0;

    logic [7:0] got_b[$];
    bit         got_p[$];
    int         got_t[$];

    sonet_frame_aligner i_sonet_frame_aligner (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .oof(oof),
        .sts12_mode(sts12_mode), .byte_out(byte_out),
        .byte_stb(byte_stb), .frame_pulse(frame_pulse)
    );

    always #2 clk = ~clk;   // 250 MHz

    // Collect delivered bytes away from the active edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && byte_stb) begin
            got_b.push_back(byte_out);
            got_p.push_back(frame_pulse);
            got_t.push_back(cyc);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Frame content: N A1 bytes, N A2 bytes, then filler that cannot form the word.
    function automatic logic [7:0] fbyte(input int k, input int n);
        if (k < n)          return 8'hF6;
        else if (k < 2 * n) return 8'h28;
        else                return {1'b0, 6'(k), 1'b0};
    endfunction

    task automatic send_bits(input int n, input bit v);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ser_in = v;
        end
    endtask

    task automatic send_frames(input int nbytes, input int n);
        for (int k = 0; k < nbytes; k++) begin
            logic [7:0] b;
            b = fbyte(k % (810 * n), n);
            for (int i = 7; i >= 0; i--) begin
                @(negedge clk);
                ser_in = b[i];
            end
        end
    endtask

    function automatic int find_pulse(input int from);
        for (int i = from; i < got_p.size(); i++) if (got_p[i]) return i;
        return -1;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Reset values, then no pulse while hunting with oof low; strobe spacing.
    task automatic t_reset();
        do_reset();
        #1;
        check(frame_pulse == 1'b0, "R1 frame_pulse after reset", frame_pulse, 0);
        check(byte_stb == 1'b0, "R1 byte_stb after reset", byte_stb, 0);
        check(byte_out == 8'h00, "R1 byte_out after reset", byte_out, 0);
        send_bits(240, 1'b0);
        check(find_pulse(0) == -1, "R1 no pulse before lock", find_pulse(0), -1);
        check(got_b.size() >= 28, "R2 strobes while hunting", got_b.size(), 29);
        check(got_t[10] - got_t[9] == 8, "R2 strobe spacing", got_t[10] - got_t[9], 8);
    endtask

    // STS-3 lock with oof low at a 3-bit offset: content, pulse width and period.
    task automatic t_sts3_lock();
        int s, p0, p1;
        s = got_b.size();
        send_bits(3, 1'b0);
        send_frames(2500, 3);
        p0 = find_pulse(s);
        check(p0 >= 0, "R3 framing word found", p0, s);
        if (p0 < 0) return;
        for (int j = 0; j < 12; j++)
            check(got_b[p0 + j] == fbyte(6 + j, 3), "R4 STS-3 byte after word",
                  got_b[p0 + j], fbyte(6 + j, 3));
        check(got_p[p0 + 1] == 1'b0, "R5 pulse lasts one byte", got_p[p0 + 1], 0);
        check(got_t[p0 + 1] - got_t[p0] == 8, "R2 spacing after lock",
              got_t[p0 + 1] - got_t[p0], 8);
        p1 = find_pulse(p0 + 1);
        check(p1 - p0 == 2430, "R6 STS-3 frame period", p1 - p0, 2430);
        last_pulse = p1;
    endtask

    // Slip the stream by 5 bits with oof low: boundary must not move.
    task automatic t_ignore_slip();
        int p;
        send_bits(5, 1'b1);
        send_frames(2500, 3);
        p = find_pulse(last_pulse + 1);
        check(p == last_pulse + 2430, "R7 slipped word ignored", p, last_pulse + 2430);
    endtask

    // Raise oof: the boundary moves to the slipped stream.
    task automatic t_rehunt();
        int s, p0, p1;
        @(negedge clk);
        oof = 1'b1;
        s = got_b.size();
        send_frames(2500, 3);
        p0 = find_pulse(s);
        check(p0 >= s && p0 - s <= 8, "R8 realign under oof", p0 - s, 6);
        if (p0 < 0) begin oof = 1'b0; return; end
        for (int j = 0; j < 6; j++)
            check(got_b[p0 + j] == fbyte(6 + j, 3), "R8 content after realign",
                  got_b[p0 + j], fbyte(6 + j, 3));
        p1 = find_pulse(p0 + 1);
        check(p1 - p0 == 2430, "R6 period after realign", p1 - p0, 2430);
        oof = 1'b0;
    endtask

    // STS-12 geometry at a 6-bit offset.
    task automatic t_sts12();
        int s, p0, p1;
        sts12_mode = 1'b1;
        do_reset();
        s = got_b.size();
        send_bits(6, 1'b0);
        send_frames(9760, 12);
        p0 = find_pulse(s);
        check(p0 >= 0, "R9 STS-12 lock", p0, s);
        if (p0 < 0) return;
        for (int j = 0; j < 12; j++)
            check(got_b[p0 + j] == fbyte(15 + j, 12), "R9 STS-12 byte after word",
                  got_b[p0 + j], fbyte(15 + j, 12));
        p1 = find_pulse(p0 + 1);
        check(p1 - p0 == 9720, "R6 STS-12 frame period", p1 - p0, 9720);
    endtask

    initial begin
        t_reset();
        t_sts3_lock();
        t_ignore_slip();
        t_rehunt();
        t_sts12();
        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(195000 * 4);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule